// File: doc/BRIEF.md
# Display Test Pattern Generator

This block drives a display panel with simple repeating test images, so the panel can be checked by eye without any video source attached. It contains its own raster timing counters. Each pixel clock it emits a 24-bit RGB value ({red, green, blue}, 8 bits each, red in the top byte) together with data-enable, horizontal sync and vertical sync.

Configuration inputs choose one of sixteen pattern codes: solid colors, horizontal ramps, vertical ramps and a programmable solid color. They also set an inversion flag that complements the color, and the active width and height. Blanking lengths are fixed by parameters. The pixel clock comes from either the external pixel clock or an internal oscillator clock, picked by a select input, so the image keeps running when no external clock is present. A power-down input holds the raster at its origin and silences all outputs.

Top module: `panel_pattern_gen`

## Requirements
- R1: While reset is asserted, rgb_o, de_o, hs_o and vs_o are all zero. The first frame after reset uses pattern 0 with no inversion, active width DEF_HACT and active height DEF_VACT.
- R2: A line lasts width+H_FP+H_SYNC+H_BP pixel clocks and a frame lasts height+V_FP+V_SYNC+V_BP lines. de_o is high for the first `width` pixels of each of the first `height` lines. The first pixel clock edge after reset (or after power-down ends) presents the top-left active pixel.
- R3: hs_o is high for H_SYNC pixels, starting H_FP pixels after the last active pixel of every line. vs_o is high for the whole of V_SYNC lines, starting V_FP lines after the last active line. Neither is ever high together with de_o.
- R4: Outside the active area rgb_o is zero, whatever the pattern or inversion.
- R5: Codes 0 to 4 give solid white, black, red (FF0000), green (00FF00) and blue (0000FF). Codes 14 and 15 give black.
- R6: Codes 5 to 8 give a horizontal ramp toward white, red, green or blue. The ramp value at column x is floor(x*256/width) on the ramp's channels and zero on the others.
- R7: Codes 9 to 12 give the same four ramps vertically. The value at active line y is floor(y*256/height).
- R8: Code 13 outputs the programmed 24-bit custom color on every active pixel.
- R9: With inversion set, each of the three channels of an active pixel is the bitwise complement of its non-inverted value. Solid colors thus turn into black, white, cyan, magenta and yellow, and ramps start at white.
- R10: Pattern, inversion, custom color, width and height are captured only on the last pixel clock of a frame. A change made mid-frame has no effect on the rest of that frame.
- R11: While pwr_dn is high, every output is zero from the next pixel clock on. After it falls, the raster restarts at the top-left pixel with the captured configuration kept.
- R12: With use_int high, the block is clocked from clk_int and runs without any edge on clk_ext. use_int may change only during reset or power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ext | input | 1 | External pixel clock |
| clk_int | input | 1 | Internal oscillator clock |
| use_int | input | 1 | 1 selects clk_int as pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Power-down: hold raster, silence outputs |
| cfg_pattern | input | 4 | Pattern code |
| cfg_invert | input | 1 | Complement the active pixel color |
| cfg_rgb | input | 24 | Custom color {R,G,B} |
| cfg_hact | input | CW | Active width in pixels |
| cfg_vact | input | CW | Active height in lines |
| rgb_o | output | 24 | Pixel color {R,G,B} |
| de_o | output | 1 | Data enable |
| hs_o | output | 1 | Horizontal sync, active high |
| vs_o | output | 1 | Vertical sync, active high |

## Verification
On every cycle the assertions enforce the following: color is silent in blanking, neither sync overlaps data-enable, power-down silences the outputs, the horizontal counter stays inside its line, and the captured pattern changes only at a frame's last pixel. The color values themselves can only be shown by the bench's scenarios. These include the ramp arithmetic at different widths and heights (including width 256), the complement of every pattern, and mid-frame configuration changes that must not show until the next frame. The same holds for the restart after power-down and the raster running from the internal clock with the external one stopped.

// File: rtl/panel_pattern_gen.sv
module panel_pattern_gen #(
  parameter int CW       = 12,
  parameter int H_FP     = 2,
  parameter int H_SYNC   = 3,
  parameter int H_BP     = 2,
  parameter int V_FP     = 1,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 1,
  parameter int DEF_HACT = 16,
  parameter int DEF_VACT = 8
) (
  input  logic          clk_ext,
  input  logic          clk_int,
  input  logic          use_int,
  input  logic          rst_n,
  input  logic          pwr_dn,
  input  logic [3:0]    cfg_pattern,
  input  logic          cfg_invert,
  input  logic [23:0]   cfg_rgb,
  input  logic [CW-1:0] cfg_hact,
  input  logic [CW-1:0] cfg_vact,
  output logic [23:0]   rgb_o,
  output logic          de_o,
  output logic          hs_o,
  output logic          vs_o
);
  localparam int TW = CW + 2;
  localparam int HB = H_FP + H_SYNC + H_BP;
  localparam int VB = V_FP + V_SYNC + V_BP;

  wire pix_clk = use_int ? clk_int : clk_ext;

  logic [TW-1:0] hcnt, vcnt;
  logic [3:0]    sel_q;
  logic          inv_q;
  logic [23:0]   rgb_q;
  logic [CW-1:0] hact_q, vact_q;

  logic [TW-1:0] hact_w, vact_w, htot, vtot, hden, vden;
  logic [7:0]    hg, vg, val;
  logic [2:0]    msk;
  logic [23:0]   pix, pix_f;
  logic          line_end, frame_end, active, hs_n, vs_n;

  assign hact_w    = TW'(hact_q);
  assign vact_w    = TW'(vact_q);
  assign htot      = hact_w + TW'(HB);
  assign vtot      = vact_w + TW'(VB);
  assign line_end  = (hcnt == htot - TW'(1));
  assign frame_end = line_end && (vcnt == vtot - TW'(1));
  assign active    = (hcnt < hact_w) && (vcnt < vact_w);
  assign hs_n      = (hcnt >= hact_w + TW'(H_FP)) && (hcnt < hact_w + TW'(H_FP + H_SYNC));
  assign vs_n      = (vcnt >= vact_w + TW'(V_FP)) && (vcnt < vact_w + TW'(V_FP + V_SYNC));

  // ramp: position scaled to 0..255 over the active span
  assign hden = (hact_q == '0) ? TW'(1) : hact_w;
  assign vden = (vact_q == '0) ? TW'(1) : vact_w;
  assign hg   = 8'({hcnt, 8'd0} / {8'd0, hden});
  assign vg   = 8'({vcnt, 8'd0} / {8'd0, vden});

  always_comb begin
    val = 8'hff;
    msk = 3'b000;
    case (sel_q)
      4'd0:  msk = 3'b111;
      4'd2:  msk = 3'b100;
      4'd3:  msk = 3'b010;
      4'd4:  msk = 3'b001;
      4'd5:  begin msk = 3'b111; val = hg; end
      4'd6:  begin msk = 3'b100; val = hg; end
      4'd7:  begin msk = 3'b010; val = hg; end
      4'd8:  begin msk = 3'b001; val = hg; end
      4'd9:  begin msk = 3'b111; val = vg; end
      4'd10: begin msk = 3'b100; val = vg; end
      4'd11: begin msk = 3'b010; val = vg; end
      4'd12: begin msk = 3'b001; val = vg; end
      default: msk = 3'b000;
    endcase
  end

  assign pix   = (sel_q == 4'd13) ? rgb_q
               : {msk[2] ? val : 8'h00, msk[1] ? val : 8'h00, msk[0] ? val : 8'h00};
  assign pix_f = inv_q ? ~pix : pix;

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      vcnt   <= '0;
      sel_q  <= '0;
      inv_q  <= 1'b0;
      rgb_q  <= '0;
      hact_q <= CW'(DEF_HACT);
      vact_q <= CW'(DEF_VACT);
      rgb_o  <= '0;
      de_o   <= 1'b0;
      hs_o   <= 1'b0;
      vs_o   <= 1'b0;
    end else if (pwr_dn) begin
      hcnt  <= '0;
      vcnt  <= '0;
      rgb_o <= '0;
      de_o  <= 1'b0;
      hs_o  <= 1'b0;
      vs_o  <= 1'b0;
    end else begin
      rgb_o <= active ? pix_f : 24'h0;
      de_o  <= active;
      hs_o  <= hs_n;
      vs_o  <= vs_n;
      if (line_end) begin
        hcnt <= '0;
        vcnt <= frame_end ? '0 : vcnt + TW'(1);
      end else begin
        hcnt <= hcnt + TW'(1);
      end
      if (frame_end) begin
        sel_q  <= cfg_pattern;
        inv_q  <= cfg_invert;
        rgb_q  <= cfg_rgb;
        hact_q <= cfg_hact;
        vact_q <= cfg_vact;
      end
    end
  end

  assert_hcnt_in_line_R2: assert property (@(posedge pix_clk) disable iff (!rst_n)
    hcnt < htot);
  assert_hs_outside_de_R3: assert property (@(posedge pix_clk) disable iff (!rst_n)
    hs_o |-> !de_o);
  assert_vs_outside_de_R3: assert property (@(posedge pix_clk) disable iff (!rst_n)
    vs_o |-> !de_o);
  assert_blank_black_R4: assert property (@(posedge pix_clk) disable iff (!rst_n)
    !de_o |-> (rgb_o == 24'h0));
  assert_sel_at_frame_end_R10: assert property (@(posedge pix_clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(frame_end));
  assert_pwr_dn_quiet_R11: assert property (@(posedge pix_clk) disable iff (!rst_n)
    pwr_dn |=> (!de_o && !hs_o && !vs_o && rgb_o == 24'h0));
endmodule

// File: tb/tb_panel_pattern_gen.sv
`timescale 1ns/1ps
module tb_panel_pattern_gen;
  localparam int CW = 12;
  localparam int HFP = 2, HS = 3, HBP = 2, VFP = 1, VS = 2, VBP = 1;
  localparam int HB = HFP + HS + HBP, VB = VFP + VS + VBP;

  logic clk_ext = 0, clk_int = 0, ext_run = 1, use_int = 0;
  logic rst_n = 0, pwr_dn = 0, cfg_invert = 0;
  logic [3:0] cfg_pattern = 0;
  logic [23:0] cfg_rgb = 0;
  logic [CW-1:0] cfg_hact = 8, cfg_vact = 4;
  logic [23:0] rgb_o;
  logic de_o, hs_o, vs_o;

  always #2.5 clk_ext = ext_run ? ~clk_ext : clk_ext;
  always #3.5 clk_int = ~clk_int;
  wire bclk = use_int ? clk_int : clk_ext;

  panel_pattern_gen #(.CW(CW), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP), .DEF_HACT(16), .DEF_VACT(8)) dut (
    .clk_ext(clk_ext), .clk_int(clk_int), .use_int(use_int), .rst_n(rst_n),
    .pwr_dn(pwr_dn), .cfg_pattern(cfg_pattern), .cfg_invert(cfg_invert),
    .cfg_rgb(cfg_rgb), .cfg_hact(cfg_hact), .cfg_vact(cfg_vact),
    .rgb_o(rgb_o), .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [23:0] exp_pixel(int sel, bit inv, logic [23:0] c,
                                            int w, int h, int x, int y);
    logic [7:0] r;
    logic [23:0] p;
    r = 8'hff;
    if (sel >= 5 && sel <= 8)  r = 8'((x * 256) / (w == 0 ? 1 : w));
    if (sel >= 9 && sel <= 12) r = 8'((y * 256) / (h == 0 ? 1 : h));
    case (sel)
      0, 5, 9:  p = {r, r, r};
      2, 6, 10: p = {r, 8'h00, 8'h00};
      3, 7, 11: p = {8'h00, r, 8'h00};
      4, 8, 12: p = {8'h00, 8'h00, r};
      13:       p = c;
      default:  p = 24'h0;
    endcase
    return inv ? ~p : p;
  endfunction

  function automatic string group_of(int sel, bit inv);
    if (inv) return "R9";
    if (sel >= 5 && sel <= 8) return "R6";
    if (sel >= 9 && sel <= 12) return "R7";
    if (sel == 13) return "R8";
    return "R5";
  endfunction

  // reference raster built from the requirements
  int hc, vc, s_sel, s_hact, s_vact;
  bit s_inv;
  logic [23:0] s_rgb, e_rgb;
  logic e_de, e_hs, e_vs;

  always @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= 0; vc <= 0; s_sel <= 0; s_inv <= 0; s_rgb <= 0; s_hact <= 16; s_vact <= 8;
      e_rgb <= 0; e_de <= 0; e_hs <= 0; e_vs <= 0;
    end else if (pwr_dn) begin
      hc <= 0; vc <= 0; e_rgb <= 0; e_de <= 0; e_hs <= 0; e_vs <= 0;
    end else begin
      e_de  <= (hc < s_hact) && (vc < s_vact);
      e_rgb <= ((hc < s_hact) && (vc < s_vact)) ? exp_pixel(s_sel, s_inv, s_rgb, s_hact, s_vact, hc, vc) : 24'h0;
      e_hs  <= (hc >= s_hact + HFP) && (hc < s_hact + HFP + HS);
      e_vs  <= (vc >= s_vact + VFP) && (vc < s_vact + VFP + VS);
      if (hc == s_hact + HB - 1) begin
        hc <= 0;
        if (vc == s_vact + VB - 1) begin
          vc <= 0;
          s_sel <= int'(cfg_pattern); s_inv <= cfg_invert; s_rgb <= cfg_rgb;
          s_hact <= int'(cfg_hact); s_vact <= int'(cfg_vact);
        end else vc <= vc + 1;
      end else hc <= hc + 1;
    end
  end

  task automatic fail(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_fail++;
    $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
  endtask

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) fail(req, what, act, exp);
  endtask

  // per-cycle comparison against the reference
  bit chk_on = 0;
  always @(negedge bclk) begin
    if (rst_n && chk_on && !done) begin
      n_chk++;
      if (de_o !== e_de) fail("R2", "de_o", 32'(de_o), 32'(e_de));
      else if (hs_o !== e_hs) fail("R3", "hs_o", 32'(hs_o), 32'(e_hs));
      else if (vs_o !== e_vs) fail("R3", "vs_o", 32'(vs_o), 32'(e_vs));
      else if (rgb_o !== e_rgb)
        fail(e_de ? group_of(s_sel, s_inv) : "R4", "rgb_o", 32'(rgb_o), 32'(e_rgb));
    end
  end

  task automatic wait_frame();
    do @(negedge bclk); while (!(hc == 0 && vc == 0));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #900000;
    n_chk++;
    fail("WATCHDOG", "timeout", 0, 0);
    summary();
  end

  initial begin
    int seed, toggles;
    logic prev_de;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    #20;
    @(negedge bclk);
    check(rgb_o == 0 && !de_o && !hs_o && !vs_o, "R1", "outputs in reset",
          {rgb_o, de_o, hs_o, vs_o, 5'd0}, 0);
    rst_n = 1;
    chk_on = 1;
    @(negedge bclk);
    check(de_o && rgb_o == 24'hffffff, "R1", "first pixel white default", {7'd0, de_o, rgb_o}, 32'h01ffffff);
    check(de_o, "R2", "first edge gives top-left active pixel", 32'(de_o), 1);

    // directed ramp corner: full-width horizontal ramp reaches 255
    cfg_pattern = 5; cfg_invert = 0; cfg_hact = 256; cfg_vact = 2;
    wait_frame();
    wait_frame();
    do @(negedge bclk); while (!(vc == 0 && hc == 256));
    check(rgb_o == 24'hffffff && de_o, "R6", "ramp at column 255 of 256", 32'(rgb_o), 32'h00ffffff);

    // random configurations, changed at random points of a frame
    for (int f = 0; f < 36; f++) begin
      cfg_pattern = 4'($urandom_range(0, 15));
      cfg_invert  = 1'($urandom_range(0, 1));
      cfg_rgb     = 24'($urandom);
      cfg_hact    = CW'($urandom_range(1, 40));
      cfg_vact    = CW'($urandom_range(1, 10));
      if (f == 30) begin cfg_pattern = 9; cfg_vact = 3; cfg_invert = 1; end
      if (f == 31) begin cfg_pattern = 13; cfg_invert = 1; end
      if (f == 32) begin cfg_pattern = 15; cfg_invert = 1; end
      wait_frame();
      repeat ($urandom_range(0, 150)) @(negedge bclk);
    end
    wait_frame();

    // R10: a mid-frame change waits for the next frame
    cfg_pattern = 0; cfg_invert = 0; cfg_hact = 8; cfg_vact = 4;
    wait_frame();
    wait_frame();
    do @(negedge bclk); while (!(vc == 1 && hc == 1));
    cfg_pattern = 2; cfg_invert = 0;
    @(negedge bclk);
    check(de_o && rgb_o == 24'hffffff, "R10", "old pattern kept mid-frame", 32'(rgb_o), 32'h00ffffff);
    wait_frame();
    @(negedge bclk);
    check(de_o && rgb_o == 24'hff0000, "R10", "new pattern at next frame", 32'(rgb_o), 32'h00ff0000);

    // R11: power-down
    repeat (5) @(negedge bclk);
    pwr_dn = 1;
    repeat (3) @(negedge bclk);
    check(rgb_o == 0 && !de_o && !hs_o && !vs_o, "R11", "quiet in power-down",
          {rgb_o, de_o, hs_o, vs_o, 5'd0}, 0);
    pwr_dn = 0;
    @(negedge bclk);
    check(de_o && rgb_o == 24'hff0000, "R11", "restart at top-left", 32'(rgb_o), 32'h00ff0000);

    // R12: internal clock with the external clock stopped
    chk_on = 0;
    rst_n = 0;
    #10;
    use_int = 1;
    ext_run = 0;
    #10;
    @(negedge bclk);
    rst_n = 1;
    chk_on = 1;
    toggles = 0;
    prev_de = de_o;
    for (int i = 0; i < 400; i++) begin
      @(negedge bclk);
      if (de_o != prev_de) toggles++;
      prev_de = de_o;
    end
    check(toggles > 10, "R12", "raster runs on internal clock", 32'(toggles), 32'd11);
    summary();
  end
endmodule